// File: doc/BRIEF.md
# Cache Line Disable and Recycle Unit

This unit sits next to a set-associative cache data array. While the boot-time self-test runs, after the supply voltage has been set, it takes a fault map for the physical lines. Each entry is a bit mask with one bit set for every faulty bit position in that line. Any line whose mask is non-zero becomes disabled and can no longer be allocated as an ordinary line. When the self-test signals that the map is complete, the unit scans the disabled lines in ascending order. It packs them into recycled groups of three whose fault positions do not overlap. Each complete group is one logical line, so every three lost lines return one usable line.

Data accesses reach the array through a valid/ready request port. The request is accepted only once the recycled-line table has been built. There is no back-pressure after acceptance: a read answers with exactly one response beat on the cycle after it is accepted, and the response cannot be stalled. A write to a recycled line drives the write strobes of all three member lines in the same cycle, with the same data. A read of a recycled line presents the three member addresses and returns the bitwise majority of the three copies. The allocation-query pins and the table-status pins are plain levels.

Top module: `line_recycle_top`

## Requirements
- R1: After reset, `alloc_hold` is 1, `fm_ready` is 1, `req_ready` is 0 and `rc_valid` is all zeros.
- R2: Fault-map writes are accepted only while `fm_ready` is high. `fm_ready` falls on the cycle after `fm_done` is seen. A map write offered after that point changes nothing. `alloc_hold` stays 1 until the table is built.
- R3: Once `alloc_hold` is 0, `alloc_ok` is 1 for a queried line whose fault mask is zero and 0 for a line whose mask has any bit set.
- R4: The scan visits disabled lines in ascending index order. It places each one into the lowest-numbered group that has fewer than three members and whose accumulated fault mask does not overlap the line's mask; a line that fits no group is dropped. Bit k of `rc_valid` is 1 exactly when group k holds three members.
- R5: An accepted write with `req_recycled`=1 to a valid group raises exactly the three `mem_we` bits of that group's member lines, with `mem_wdata` equal to `req_wdata`.
- R6: An accepted read with `req_recycled`=1 to a valid group returns, for each bit, the value held by at least two of the three member copies.
- R7: An accepted ordinary write (`req_recycled`=0) to a clean line raises only that line's `mem_we` bit. A write to a disabled ordinary line, or to a recycled index whose group is not valid, raises no `mem_we` bit.
- R8: A read of a disabled ordinary line or of an invalid recycled index returns all zeros.
- R9: `req_ready` is 0 until the table is built. A read accepted on one clock edge gives `rsp_valid`=1 for exactly the following cycle, carrying the read data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fm_valid | input | 1 | Fault-map entry offered |
| fm_ready | output | 1 | Fault map open for loading |
| fm_line | input | IDX_W | Physical line of the entry |
| fm_mask | input | DATA_W | Faulty bit positions of that line |
| fm_done | input | 1 | Self-test finished, start grouping |
| alloc_hold | output | 1 | Allocation held off until table is built |
| q_line | input | IDX_W | Line being considered for allocation |
| alloc_ok | output | 1 | Queried line may be allocated |
| rc_valid | output | NUM_GROUPS | Per-group valid bits of the recycled table |
| req_valid | input | 1 | Access request offered |
| req_ready | output | 1 | Access request can be accepted |
| req_write | input | 1 | 1 = write, 0 = read |
| req_recycled | input | 1 | 1 = index names a recycled group |
| req_idx | input | IDX_W | Physical line or group index |
| req_wdata | input | DATA_W | Write data |
| mem_we | output | NUM_LINES | Per-line write strobes to the array |
| mem_wdata | output | DATA_W | Write data to the array |
| mem_raddr0 | output | IDX_W | First read address |
| mem_raddr1 | output | IDX_W | Second read address |
| mem_raddr2 | output | IDX_W | Third read address |
| mem_rdata0 | input | DATA_W | Data at first read address, same cycle |
| mem_rdata1 | input | DATA_W | Data at second read address, same cycle |
| mem_rdata2 | input | DATA_W | Data at third read address, same cycle |
| rsp_valid | output | 1 | Read response beat |
| rsp_data | output | DATA_W | Read response data |

## Verification
The assertions assume that the array returns read data in the same cycle as the address, and that `fm_done` arrives only after every faulty line has been loaded. They also assume that `req_idx` stays inside the line count for ordinary accesses and inside the group count for recycled ones. The bench models the array as registers with a bitwise flip on each faulty position, keeps all indices within range, and gives `fm_done` a one-cycle pulse after the last map entry. The fault masks are chosen so that one group forms with no conflicts, one forms only after a conflicting line is pushed to a later group, and one partial group is left invalid.

// File: rtl/line_recycle_pkg.sv
package line_recycle_pkg;

  typedef enum logic [1:0] {
    PH_LOAD = 2'd0,
    PH_SCAN = 2'd1,
    PH_RUN  = 2'd2
  } phase_t;

endpackage

// File: rtl/lr_fault_map.sv
module lr_fault_map #(
  parameter int NUM_LINES = 12,
  parameter int DATA_W    = 8,
  localparam int IDX_W    = $clog2(NUM_LINES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_mask,
  output logic [DATA_W-1:0] mask_o [NUM_LINES],
  output logic [NUM_LINES-1:0] disabled_o
);

  logic [DATA_W-1:0] mask_q [NUM_LINES];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_LINES; i++) mask_q[i] <= '0;
    end else if (wr_en && (int'(wr_idx) < NUM_LINES)) begin
      mask_q[wr_idx] <= wr_mask;
    end
  end

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
    assign mask_o[g]     = mask_q[g];
    assign disabled_o[g] = |mask_q[g];
  end

endmodule

// File: rtl/lr_group_builder.sv
module lr_group_builder #(
  parameter int NUM_LINES  = 12,
  parameter int DATA_W     = 8,
  localparam int IDX_W     = $clog2(NUM_LINES),
  localparam int NUM_GROUPS = NUM_LINES / 3,
  localparam int GRP_W     = (NUM_GROUPS > 1) ? $clog2(NUM_GROUPS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [DATA_W-1:0] masks_i [NUM_LINES],
  output logic              done_o,
  output logic [IDX_W-1:0]  member_o [NUM_GROUPS][3],
  output logic [NUM_GROUPS-1:0] valid_o
);

  logic              active_q;
  logic [IDX_W-1:0]  scan_q;
  logic [1:0]        cnt_q [NUM_GROUPS];
  logic [DATA_W-1:0] acc_q [NUM_GROUPS];
  logic [IDX_W-1:0]  mbr_q [NUM_GROUPS][3];

  logic [DATA_W-1:0] cur_mask;
  logic              fit;
  logic [GRP_W-1:0]  pick;

  assign cur_mask = masks_i[scan_q];

  // first open group, lowest index first, with disjoint fault positions
  always_comb begin
    fit  = 1'b0;
    pick = '0;
    for (int s = 0; s < NUM_GROUPS; s++) begin
      if (!fit && (cnt_q[s] != 2'd3) && ((acc_q[s] & cur_mask) == '0)) begin
        fit  = 1'b1;
        pick = GRP_W'(s);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      done_o   <= 1'b0;
      scan_q   <= '0;
      for (int s = 0; s < NUM_GROUPS; s++) begin
        cnt_q[s] <= '0;
        acc_q[s] <= '0;
        for (int m = 0; m < 3; m++) mbr_q[s][m] <= '0;
      end
    end else if (start && !active_q && !done_o) begin
      active_q <= 1'b1;
      scan_q   <= '0;
    end else if (active_q) begin
      if ((cur_mask != '0) && fit) begin
        mbr_q[pick][cnt_q[pick]] <= scan_q;
        cnt_q[pick]              <= cnt_q[pick] + 2'd1;
        acc_q[pick]              <= acc_q[pick] | cur_mask;
      end
      if (int'(scan_q) == NUM_LINES - 1) begin
        active_q <= 1'b0;
        done_o   <= 1'b1;
      end else begin
        scan_q <= scan_q + 1'b1;
      end
    end
  end

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
    assign valid_o[g] = done_o && (cnt_q[g] == 2'd3);
    for (genvar m = 0; m < 3; m++) begin : g_mbr
      assign member_o[g][m] = mbr_q[g][m];
    end
  end

  // R4
  table_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> $stable(valid_o));

endmodule

// File: rtl/lr_vote.sv
module lr_vote #(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic [DATA_W-1:0] c_i,
  output logic [DATA_W-1:0] y_o
);

  for (genvar k = 0; k < DATA_W; k++) begin : g_bit
    assign y_o[k] = (a_i[k] & b_i[k]) | (a_i[k] & c_i[k]) | (b_i[k] & c_i[k]);
  end

endmodule

// File: rtl/line_recycle_top.sv
module line_recycle_top #(
  parameter int NUM_LINES   = 12,
  parameter int DATA_W      = 8,
  localparam int IDX_W      = $clog2(NUM_LINES),
  localparam int NUM_GROUPS = NUM_LINES / 3,
  localparam int GRP_W      = (NUM_GROUPS > 1) ? $clog2(NUM_GROUPS) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  fm_valid,
  output logic                  fm_ready,
  input  logic [IDX_W-1:0]      fm_line,
  input  logic [DATA_W-1:0]     fm_mask,
  input  logic                  fm_done,
  output logic                  alloc_hold,
  input  logic [IDX_W-1:0]      q_line,
  output logic                  alloc_ok,
  output logic [NUM_GROUPS-1:0] rc_valid,
  input  logic                  req_valid,
  output logic                  req_ready,
  input  logic                  req_write,
  input  logic                  req_recycled,
  input  logic [IDX_W-1:0]      req_idx,
  input  logic [DATA_W-1:0]     req_wdata,
  output logic [NUM_LINES-1:0]  mem_we,
  output logic [DATA_W-1:0]     mem_wdata,
  output logic [IDX_W-1:0]      mem_raddr0,
  output logic [IDX_W-1:0]      mem_raddr1,
  output logic [IDX_W-1:0]      mem_raddr2,
  input  logic [DATA_W-1:0]     mem_rdata0,
  input  logic [DATA_W-1:0]     mem_rdata1,
  input  logic [DATA_W-1:0]     mem_rdata2,
  output logic                  rsp_valid,
  output logic [DATA_W-1:0]     rsp_data
);
  import line_recycle_pkg::*;

  phase_t phase_q;
  logic [DATA_W-1:0]    masks [NUM_LINES];
  logic [NUM_LINES-1:0] disabled;
  logic                 built;
  logic [IDX_W-1:0]     member [NUM_GROUPS][3];
  logic [DATA_W-1:0]    voted;
  logic                 fire, hit;
  logic [GRP_W-1:0]     grp;

  assign fm_ready   = (phase_q == PH_LOAD);
  assign alloc_hold = (phase_q != PH_RUN);
  assign req_ready  = (phase_q == PH_RUN);
  assign fire       = req_valid && req_ready;

  lr_fault_map #(.NUM_LINES(NUM_LINES), .DATA_W(DATA_W)) u_map (
    .clk(clk), .rst_n(rst_n),
    .wr_en(fm_valid && fm_ready), .wr_idx(fm_line), .wr_mask(fm_mask),
    .mask_o(masks), .disabled_o(disabled)
  );

  lr_group_builder #(.NUM_LINES(NUM_LINES), .DATA_W(DATA_W)) u_grp (
    .clk(clk), .rst_n(rst_n),
    .start(phase_q == PH_SCAN), .masks_i(masks),
    .done_o(built), .member_o(member), .valid_o(rc_valid)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) phase_q <= PH_LOAD;
    else begin
      case (phase_q)
        PH_LOAD: if (fm_done) phase_q <= PH_SCAN;
        PH_SCAN: if (built)   phase_q <= PH_RUN;
        default: phase_q <= PH_RUN;
      endcase
    end
  end

  assign alloc_ok = !alloc_hold && (int'(q_line) < NUM_LINES) && !disabled[q_line];

  // resolve the request to one or three physical lines
  assign grp = GRP_W'(req_idx);
  always_comb begin
    if (req_recycled) begin
      hit        = (int'(req_idx) < NUM_GROUPS) && rc_valid[grp];
      mem_raddr0 = hit ? member[grp][0] : '0;
      mem_raddr1 = hit ? member[grp][1] : '0;
      mem_raddr2 = hit ? member[grp][2] : '0;
    end else begin
      hit        = (int'(req_idx) < NUM_LINES) && !disabled[req_idx];
      mem_raddr0 = req_idx;
      mem_raddr1 = req_idx;
      mem_raddr2 = req_idx;
    end
  end

  always_comb begin
    mem_we = '0;
    if (fire && req_write && hit) begin
      mem_we[mem_raddr0] = 1'b1;
      mem_we[mem_raddr1] = 1'b1;
      mem_we[mem_raddr2] = 1'b1;
    end
  end
  assign mem_wdata = req_wdata;

  lr_vote #(.DATA_W(DATA_W)) u_vote (
    .a_i(mem_rdata0), .b_i(mem_rdata1), .c_i(mem_rdata2), .y_o(voted)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= fire && !req_write;
      if (fire && !req_write) rsp_data <= hit ? voted : '0;
    end
  end

  // R5
  rc_write_three_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && req_write && req_recycled && hit) |-> ($countones(mem_we) == 3));

  // R7
  plain_write_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && req_write && !req_recycled) |-> ($countones(mem_we) <= 1));

  // R9
  rsp_next_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !req_write) |=> rsp_valid);

  // R9
  no_access_early_chk: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_hold |-> (mem_we == '0));

  // R3
  clean_alloc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_ok |-> (masks[q_line] == '0));

endmodule

// File: tb/line_recycle_top_tb_top.sv
`timescale 1ns/1ps
module line_recycle_top_tb_top;
  localparam int NL = 12;
  localparam int DW = 8;
  localparam int IW = 4;
  localparam int NG = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic fm_valid = 1'b0, fm_done = 1'b0;
  logic fm_ready;
  logic [IW-1:0] fm_line = '0;
  logic [DW-1:0] fm_mask = '0;
  logic alloc_hold, alloc_ok;
  logic [IW-1:0] q_line = '0;
  logic [NG-1:0] rc_valid;
  logic req_valid = 1'b0, req_write = 1'b0, req_recycled = 1'b0;
  logic req_ready;
  logic [IW-1:0] req_idx = '0;
  logic [DW-1:0] req_wdata = '0;
  logic [NL-1:0] mem_we;
  logic [DW-1:0] mem_wdata;
  logic [IW-1:0] mem_raddr0, mem_raddr1, mem_raddr2;
  logic [DW-1:0] mem_rdata0, mem_rdata1, mem_rdata2;
  logic rsp_valid;
  logic [DW-1:0] rsp_data;

  line_recycle_top #(.NUM_LINES(NL), .DATA_W(DW)) dut_i (.*);

  // array model: faulty bit positions read back inverted
  logic [DW-1:0] arr [NL];
  logic [DW-1:0] flt [NL];
  initial for (int i = 0; i < NL; i++) begin arr[i] = '0; flt[i] = '0; end
  always @(posedge clk)
    for (int i = 0; i < NL; i++) if (mem_we[i]) arr[i] <= mem_wdata;
  assign mem_rdata0 = arr[mem_raddr0] ^ flt[mem_raddr0];
  assign mem_rdata1 = arr[mem_raddr1] ^ flt[mem_raddr1];
  assign mem_rdata2 = arr[mem_raddr2] ^ flt[mem_raddr2];

  int n_vec = 0, n_bad = 0;
  bit finished = 0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // {write, recycled, idx, data, expected strobes}
  typedef struct packed {
    logic          wr;
    logic          rc;
    logic [IW-1:0] idx;
    logic [DW-1:0] data;
    logic [NL-1:0] we;
  } vec_t;

  localparam vec_t VECS [13] = '{
    '{1'b1, 1'b0, 4'd0, 8'hA5, 12'h001},
    '{1'b0, 1'b0, 4'd0, 8'hA5, 12'h000},
    '{1'b1, 1'b1, 4'd0, 8'h3C, 12'h00E},
    '{1'b0, 1'b1, 4'd0, 8'h3C, 12'h000},
    '{1'b1, 1'b1, 4'd1, 8'hC3, 12'h0D0},
    '{1'b0, 1'b1, 4'd1, 8'hC3, 12'h000},
    '{1'b1, 1'b0, 4'd1, 8'hFF, 12'h000},
    '{1'b0, 1'b1, 4'd0, 8'h3C, 12'h000},
    '{1'b1, 1'b1, 4'd2, 8'h77, 12'h000},
    '{1'b0, 1'b1, 4'd2, 8'h00, 12'h000},
    '{1'b1, 1'b0, 4'd8, 8'h5A, 12'h100},
    '{1'b0, 1'b0, 4'd8, 8'h5A, 12'h000},
    '{1'b0, 1'b0, 4'd5, 8'h00, 12'h000}
  };

  task automatic load(input int line, input logic [DW-1:0] m);
    @(negedge clk);
    fm_valid = 1'b1; fm_line = IW'(line); fm_mask = m; flt[line] = m;
    @(negedge clk);
    fm_valid = 1'b0;
  endtask

  initial begin
    string lbl;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 alloc_hold", 32'(alloc_hold), 32'd1);
    check("R1 fm_ready", 32'(fm_ready), 32'd1);
    check("R1 req_ready", 32'(req_ready), 32'd0);
    check("R1 rc_valid", 32'(rc_valid), 32'd0);
    rst_n = 1'b1;

    load(1, 8'h01); load(2, 8'h02); load(3, 8'h04);
    load(4, 8'h01); load(5, 8'h01); load(6, 8'h10);
    load(7, 8'h20); load(9, 8'h02);

    @(negedge clk); fm_done = 1'b1;
    @(negedge clk); fm_done = 1'b0;
    // R2 map closes, late entry offered to clean line 0 must be ignored
    check("R2 fm_ready after done", 32'(fm_ready), 32'd0);
    check("R2 hold during scan", 32'(alloc_hold), 32'd1);
    fm_valid = 1'b1; fm_line = '0; fm_mask = 8'hFF;
    @(negedge clk); fm_valid = 1'b0;

    for (int w = 0; w < 40 && !req_ready; w++) @(negedge clk);
    check("R9 ready after build", 32'(req_ready), 32'd1);
    check("R2 hold released", 32'(alloc_hold), 32'd0);

    // R3 allocation queries
    q_line = 4'd0;  #1 check("R3 line0 clean (late map write ignored)", 32'(alloc_ok), 32'd1);
    q_line = 4'd1;  #1 check("R3 line1 faulty", 32'(alloc_ok), 32'd0);
    q_line = 4'd7;  #1 check("R3 line7 faulty", 32'(alloc_ok), 32'd0);
    q_line = 4'd11; #1 check("R3 line11 clean", 32'(alloc_ok), 32'd1);
    // R4 groups {1,2,3},{4,6,7} full; {5,9} partial; last empty
    check("R4 rc_valid", 32'(rc_valid), 32'h3);

    for (int v = 0; v < 13; v++) begin
      @(negedge clk);
      req_valid = 1'b1; req_write = VECS[v].wr; req_recycled = VECS[v].rc;
      req_idx = VECS[v].idx; req_wdata = VECS[v].data;
      #1;
      if (VECS[v].wr) lbl = (VECS[v].we == '0) ? "R7 ignored write" : (VECS[v].rc ? "R5 strobes" : "R7 strobes");
      else lbl = "R7 no strobe on read";
      check(lbl, 32'(mem_we), 32'(VECS[v].we));
      if (VECS[v].wr && VECS[v].we != '0) check("R5 wdata", 32'(mem_wdata), 32'(VECS[v].data));
      @(negedge clk);
      req_valid = 1'b0;
      if (!VECS[v].wr) begin
        lbl = (VECS[v].data == '0) ? "R8 zero read" : (VECS[v].rc ? "R6 majority" : "R9 plain read");
        check("R9 rsp_valid", 32'(rsp_valid), 32'd1);
        check(lbl, 32'(rsp_data), 32'(VECS[v].data));
        @(negedge clk);
        check("R9 single beat", 32'(rsp_valid), 32'd0);
      end
    end

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      n_vec++; n_bad++;
      $display("FAIL R9 watchdog expired actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

endmodule